// File: doc/BRIEF.md
# Memory Tag Check Unit

This unit sits on the access path of a load/store pipeline and checks each memory access against a small per-granule tag. The address space is cut into 16-byte granules, and each granule owns a 4-bit tag held in an internal tag table. Every pointer carries its own 4-bit tag in its upper bits. On each accepted access the unit looks up the granule's tag and compares it with the pointer's tag. One cycle later it reports whether the access may proceed.

If the two tags differ, the mismatch mode sampled with the request selects one of three responses. A synchronous trap blocks the access and raises a one-cycle fault pulse that carries the address. Asynchronous logging lets the access complete, sets a sticky flag and keeps the first offending address until software clears it. Silent mode lets the access pass with no trace. A separate write port sets the tag of any granule in the table.

Top module: `mem_tag_check`

## Requirements
- R1: While reset is held, and in the first cycle after reset, rsp_valid, trap_pulse and flt_sticky are 0. Every table entry resets to tag 0, and req_ready reads 1 from the first clock edge after reset is released.
- R2: An access is accepted on a rising edge where req_valid and req_ready are both 1. rsp_valid is 1 in exactly the cycle after each accepted access and 0 after a cycle with no acceptance.
- R3: When the pointer tag equals the granule tag, the response has rsp_allow=1 and trap_pulse=0, and flt_sticky is not set, whatever the mode.
- R4: The granule index is req_addr[9:4]. Bits [3:0] (the offset inside the granule) and all address bits outside [9:4] and [59:56] have no effect on the check, so every offset inside a matching granule passes.
- R5: The pointer tag is req_addr[59:56].
- R6: In mode 2'b01 (synchronous trap), a mismatch gives rsp_allow=0 and trap_pulse=1 in the response cycle, with trap_addr equal to the full request address. trap_pulse is 0 in the next cycle if no further mismatch is accepted.
- R7: In mode 2'b10 (asynchronous log), a mismatch gives rsp_allow=1 and trap_pulse=0. flt_sticky becomes 1 in the response cycle and flt_addr captures the address. Later mismatches leave flt_addr unchanged while the flag stays set.
- R8: A flt_clr pulse drops flt_sticky on the next edge. If flt_clr and a new asynchronous mismatch occur on the same edge, the flag stays set and flt_addr takes the new address.
- R9: In modes 2'b00 and 2'b11 (silent), a mismatch gives rsp_allow=1 and trap_pulse=0, and flt_sticky and flt_addr do not change.
- R10: A tag write (tw_en, tw_idx, tw_tag) takes effect at the clock edge. A check accepted on the same edge for the same granule uses the old tag, and checks accepted on later edges use the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Mismatch response mode, sampled with each request |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can accept an access |
| req_addr | input | 64 | Tagged access address |
| tw_en | input | 1 | Tag table write enable |
| tw_idx | input | 6 | Granule index to write |
| tw_tag | input | 4 | Tag value to write |
| rsp_valid | output | 1 | Check result present |
| rsp_allow | output | 1 | Access may proceed |
| trap_pulse | output | 1 | Synchronous fault pulse |
| trap_addr | output | 64 | Address of the checked access |
| flt_clr | input | 1 | Clear the asynchronous fault flag |
| flt_sticky | output | 1 | Asynchronous fault seen since last clear |
| flt_addr | output | 64 | First asynchronous faulting address |

## Verification
The bench checks two accesses to the extreme offsets 0 and 15 of one granule, and an access whose address differs only above the index field. A design that used the wrong index bits would fail these. It writes a tag and checks the same granule on the same edge: a table with a write-through read would see the new tag and miss the expected trap. It sends a second asynchronous fault, then a clear together with a new fault. A log that overwrote the captured address, or that let the clear win over the new fault, would report the wrong flt_addr or flag. Both silent encodings are tried to confirm that neither traps nor logs.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int ADDR_W    = 64;
  localparam int TAG_W     = 4;
  localparam int GRAN_BITS = 4;
  localparam int IDX_W     = 6;
  localparam int TAG_LSB   = 56;

  typedef enum logic [1:0] {
    MODE_QUIET  = 2'b00,
    MODE_TRAP   = 2'b01,
    MODE_LOG    = 2'b10,
    MODE_QUIET2 = 2'b11
  } mtc_mode_e;

  function automatic logic [IDX_W-1:0] granule_of(input logic [ADDR_W-1:0] a);
    return a[GRAN_BITS +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] ptr_tag_of(input logic [ADDR_W-1:0] a);
    return a[TAG_LSB +: TAG_W];
  endfunction

  function automatic logic tags_differ(input logic [TAG_W-1:0] p,
                                       input logic [TAG_W-1:0] g);
    return p != g;
  endfunction
endpackage

// File: rtl/mtc_tag_ram.sv
module mtc_tag_ram #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  // read sees the stored value before any write at this edge
  assign rd_tag = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_tag;
    end
  end
endmodule

// File: rtl/mtc_check_stage.sv
module mtc_check_stage
  import mtc_pkg::*;
#(
  parameter int AW = 64,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [AW-1:0] addr,
  input  logic [TW-1:0] ptr_tag,
  input  logic [TW-1:0] gran_tag,
  input  mtc_mode_e     mode,
  output logic          rsp_valid,
  output logic          rsp_allow,
  output logic          trap_pulse,
  output logic [AW-1:0] trap_addr,
  output logic          mismatch_q,
  output logic          log_fire
);
  logic mismatch;
  logic block;

  assign mismatch = tags_differ(ptr_tag, gran_tag);
  assign block    = acc && mismatch && (mode == MODE_TRAP);
  assign log_fire = acc && mismatch && (mode == MODE_LOG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      trap_pulse <= 1'b0;
      trap_addr  <= '0;
      mismatch_q <= 1'b0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_allow  <= !block;
        trap_pulse <= block;
        trap_addr  <= addr;
        mismatch_q <= mismatch;
      end else begin
        rsp_allow  <= 1'b0;
        trap_pulse <= 1'b0;
        mismatch_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mtc_fault_log.sv
module mtc_fault_log #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          log_fire,
  input  logic [AW-1:0] addr,
  input  logic          clr,
  output logic          sticky,
  output logic [AW-1:0] first_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky     <= 1'b0;
      first_addr <= '0;
    end else if (log_fire) begin
      if (!sticky || clr) first_addr <= addr;
      sticky <= 1'b1;
    end else if (clr) begin
      sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_tag_check.sv
module mem_tag_check
  import mtc_pkg::*;
#(
  parameter int AW  = mtc_pkg::ADDR_W,
  parameter int TW  = mtc_pkg::TAG_W,
  parameter int IW  = mtc_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          tw_en,
  input  logic [IW-1:0] tw_idx,
  input  logic [TW-1:0] tw_tag,
  output logic          rsp_valid,
  output logic          rsp_allow,
  output logic          trap_pulse,
  output logic [AW-1:0] trap_addr,
  input  logic          flt_clr,
  output logic          flt_sticky,
  output logic [AW-1:0] flt_addr
);
  logic          rdy_q;
  logic          acc;
  logic [IW-1:0] look_idx;
  logic [TW-1:0] look_tag;
  logic [TW-1:0] ptr_tag;
  logic          stg_mismatch;
  logic          log_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign req_ready = rdy_q;
  assign acc       = req_valid && rdy_q;
  assign look_idx  = granule_of(req_addr);
  assign ptr_tag   = ptr_tag_of(req_addr);

  mtc_tag_ram #(.IDX_W(IW), .TAG_W(TW)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tw_en),
    .wr_idx (tw_idx),
    .wr_tag (tw_tag),
    .rd_idx (look_idx),
    .rd_tag (look_tag)
  );

  mtc_check_stage #(.AW(AW), .TW(TW)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .addr       (req_addr),
    .ptr_tag    (ptr_tag),
    .gran_tag   (look_tag),
    .mode       (mtc_mode_e'(cfg_mode)),
    .rsp_valid  (rsp_valid),
    .rsp_allow  (rsp_allow),
    .trap_pulse (trap_pulse),
    .trap_addr  (trap_addr),
    .mismatch_q (stg_mismatch),
    .log_fire   (log_fire)
  );

  mtc_fault_log #(.AW(AW)) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .log_fire   (log_fire),
    .addr       (req_addr),
    .clr        (flt_clr),
    .sticky     (flt_sticky),
    .first_addr (flt_addr)
  );
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_allow,
  input logic          trap_pulse,
  input logic          flt_clr,
  input logic          flt_sticky,
  input logic [AW-1:0] flt_addr,
  input logic          stg_mismatch,
  input logic          log_fire
);
  // R2: a response follows every accepted access
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2: no response without an acceptance
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R3: matching tags always pass
  a_r3_match_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !stg_mismatch) |-> (rsp_allow && !trap_pulse));

  // R6: a trap only with a blocked, valid, mismatching response
  a_r6_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (rsp_valid && !rsp_allow && stg_mismatch));

  // R6: blocking only happens together with a trap
  a_r6_block_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_allow) |-> trap_pulse);

  // R7: captured address holds while the flag stays uncleared
  a_r7_first_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_sticky && !flt_clr) |=> (flt_sticky && $stable(flt_addr)));

  // R8: clear without a new fault drops the flag
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clr && !log_fire) |=> !flt_sticky);

  // R7: a logged fault sets the flag
  a_r7_log_sets: assert property (@(posedge clk) disable iff (!rst_n)
    log_fire |=> flt_sticky);
endmodule

bind mem_tag_check mtc_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_allow    (rsp_allow),
  .trap_pulse   (trap_pulse),
  .flt_clr      (flt_clr),
  .flt_sticky   (flt_sticky),
  .flt_addr     (flt_addr),
  .stg_mismatch (stg_mismatch),
  .log_fire     (log_fire)
);

// File: tb/tb_mem_tag_check.sv
module tb_mem_tag_check;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        tw_en = 1'b0;
  logic [5:0]  tw_idx = '0;
  logic [3:0]  tw_tag = '0;
  logic        rsp_valid, rsp_allow, trap_pulse, flt_sticky;
  logic [63:0] trap_addr, flt_addr;
  logic        flt_clr = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_tag_check dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_tag(tw_tag),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .trap_pulse(trap_pulse), .trap_addr(trap_addr),
    .flt_clr(flt_clr), .flt_sticky(flt_sticky), .flt_addr(flt_addr)
  );

  function automatic logic [63:0] mk(input logic [3:0] tag, input logic [5:0] idx,
                                     input logic [3:0] off, input logic hi);
    logic [63:0] a = '0;
    a[59:56] = tag;
    a[9:4]   = idx;
    a[3:0]   = off;
    a[30]    = hi;
    return a;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access; outputs sampled just after the response edge
  task automatic access(input logic [63:0] a, input logic [1:0] m, input logic clr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; cfg_mode = m; flt_clr = clr;
    @(posedge clk); #1;
    @(negedge clk);
    req_valid = 1'b0; flt_clr = 1'b0;
  endtask

  // sample: outputs visible in the cycle after acceptance
  task automatic access_chk(input string tag, input logic [63:0] a, input logic [1:0] m,
                            input logic exp_allow, input logic exp_trap);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; cfg_mode = m;
    @(posedge clk); #1;
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " allow"}, 64'(rsp_allow), 64'(exp_allow));
    chk({tag, " trap"}, 64'(trap_pulse), 64'(exp_trap));
    if (exp_trap) chk({tag, " trap_addr"}, trap_addr, a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_tag(input logic [5:0] idx, input logic [3:0] t);
    @(negedge clk);
    tw_en = 1'b1; tw_idx = idx; tw_tag = t;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1 ready in reset", 64'(req_ready), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1 trap after reset", 64'(trap_pulse), 64'd0);
    chk("R1 sticky after reset", 64'(flt_sticky), 64'd0);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    access_chk("R1 tag0 default", mk(4'h0, 6'd33, 4'h7, 1'b0), 2'b01, 1'b1, 1'b0);
    @(posedge clk); #1;
    chk("R2 idle no rsp", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_match;
    write_tag(6'd5, 4'hA);
    access_chk("R3 R5 match off0", mk(4'hA, 6'd5, 4'h0, 1'b0), 2'b01, 1'b1, 1'b0);
    access_chk("R4 match off15", mk(4'hA, 6'd5, 4'hF, 1'b0), 2'b01, 1'b1, 1'b0);
    access_chk("R4 alias high bit", mk(4'hA, 6'd5, 4'h3, 1'b1), 2'b10, 1'b1, 1'b0);
    chk("R3 no log on match", 64'(flt_sticky), 64'd0);
    access_chk("R10 new tag used", mk(4'h0, 6'd5, 4'h0, 1'b0), 2'b01, 1'b0, 1'b1);
  endtask

  task automatic t_trap;
    logic [63:0] a = mk(4'h3, 6'd5, 4'h9, 1'b0);
    access_chk("R6 sync mismatch", a, 2'b01, 1'b0, 1'b1);
    @(posedge clk); #1;
    chk("R6 trap one cycle", 64'(trap_pulse), 64'd0);
    chk("R6 no log", 64'(flt_sticky), 64'd0);
  endtask

  task automatic t_silent;
    access_chk("R9 silent 00", mk(4'h1, 6'd5, 4'h0, 1'b0), 2'b00, 1'b1, 1'b0);
    access_chk("R9 silent 11", mk(4'h2, 6'd5, 4'h0, 1'b0), 2'b11, 1'b1, 1'b0);
    chk("R9 sticky unchanged", 64'(flt_sticky), 64'd0);
  endtask

  task automatic t_async;
    logic [63:0] a1 = mk(4'h4, 6'd5, 4'h2, 1'b0);
    logic [63:0] a2 = mk(4'h6, 6'd5, 4'h8, 1'b1);
    logic [63:0] a3 = mk(4'h7, 6'd5, 4'h1, 1'b0);
    access_chk("R7 async first", a1, 2'b10, 1'b1, 1'b0);
    chk("R7 sticky set", 64'(flt_sticky), 64'd1);
    chk("R7 first addr", flt_addr, a1);
    access_chk("R7 async second", a2, 2'b10, 1'b1, 1'b0);
    chk("R7 addr kept", flt_addr, a1);
    access_chk("R9 silent keeps log", a3, 2'b00, 1'b1, 1'b0);
    chk("R9 addr kept", flt_addr, a1);
    @(negedge clk); flt_clr = 1'b1;
    @(posedge clk); #1;
    chk("R8 clear drops", 64'(flt_sticky), 64'd0);
    @(negedge clk); flt_clr = 1'b0;
    access(a1, 2'b10, 1'b0);
    access(a3, 2'b10, 1'b1);
    chk("R8 clear+fault sticky", 64'(flt_sticky), 64'd1);
    chk("R8 clear+fault addr", flt_addr, a3);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    tw_en = 1'b1; tw_idx = 6'd7; tw_tag = 4'h9;
    req_valid = 1'b1; req_addr = mk(4'h9, 6'd7, 4'h4, 1'b0); cfg_mode = 2'b01;
    @(posedge clk); #1;
    chk("R10 same edge old tag", 64'(trap_pulse), 64'd1);
    chk("R10 same edge blocked", 64'(rsp_allow), 64'd0);
    @(negedge clk);
    tw_en = 1'b0; req_valid = 1'b0;
    access_chk("R10 later new tag", mk(4'h9, 6'd7, 4'h4, 1'b0), 2'b01, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_match();
    t_trap();
    t_silent();
    t_async();
    t_same_edge();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule